// File: doc/BRIEF.md
# Bus write width adapter

This block takes CPU-side writes of five sizes (byte, halfword, word, doubleword and quadword) and converts each one into a form that a 128-bit peripheral register space accepts. Ordinary register pages only take aligned 32-bit word writes. Four pages of that space are FIFO windows, and each of them takes full 128-bit beats.

A narrow write to a FIFO page is zero-filled into one lane of a beat. A wide write to an ordinary page is cut down to its lowest word. A byte or halfword write runs a read-modify-write on the 32-bit register that contains it. While that sequence runs, a busy output holds off further requests. A request whose address is not aligned to its size, or whose size code is unknown, raises a one-cycle error pulse and writes nothing.

Top module: `bus_write_adapter`

## Requirements
- R1: After reset, busy, errFlag, regWrEn and regRdEn are low and fifoValid is all zeros.
- R2: A request is accepted on a clock edge where reqValid is high and busy is low. Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword and 4 quadword. An accepted word write (code 2) to a non-FIFO page causes exactly one regWrEn cycle in the next cycle, carrying the request address and data bits 31:0.
- R3: A doubleword or quadword write (codes 3, 4) to a non-FIFO page causes one regWrEn cycle in the next cycle, at the request address, carrying only reqData bits 31:0.
- R4: A word write to a FIFO page issues a beat in the next cycle. The beat is all zeros except lane k = address bits 3:2, which occupies bits 32k+31:32k and carries the word. fifoAddr is the request address with bits 3:0 cleared.
- R5: A doubleword write to a FIFO page issues a zero-filled beat. The doubleword sits in half h = address bit 3, at bits 64h+63:64h.
- R6: A quadword write to a FIFO page issues the 128 data bits unchanged as the beat.
- R7: The page is address bits 15:12. Pages 4, 5 and 6 raise fifoValid bits 0, 1 and 2. Page 7 with address bit 4 set raises fifoValid bit 3. At most one sink strobe (register read, register write or a FIFO bit) is active in any cycle.
- R8: A word, doubleword or quadword write to page 7 with address bit 4 clear produces no strobe of any kind.
- R9: A byte write runs in two cycles. In the cycle after acceptance, regRdEn is high with regRdAddr equal to the address with bits 1:0 cleared. In the following cycle, regWrEn writes back the returned word at the same address, with byte k = address bits 1:0 (bits 8k+7:8k) replaced by reqData bits 7:0.
- R10: A halfword write follows the same two-cycle sequence and replaces halfword h = address bit 1 (bits 16h+15:16h) with reqData bits 15:0.
- R11: busy is high during both cycles of a read-modify-write, and any request presented while busy is high is ignored.
- R12: A misaligned request raises errFlag for one cycle in the next cycle and produces no write. Misaligned means a halfword with bit 0 set, a word with bits 1:0 nonzero, a doubleword with bits 2:0 nonzero, or a quadword with bits 3:0 nonzero. An unknown size code (5 to 7) does the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Write request present |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqSize | input | 3 | Size code (0 byte to 4 quadword) |
| reqData | input | 128 | Write data, right-aligned |
| busy | output | 1 | Read-modify-write in progress; requests ignored |
| errFlag | output | 1 | One-cycle pulse for a misaligned or unknown request |
| regWrEn | output | 1 | Register word write strobe |
| regWrAddr | output | ADDR_W | Register write address |
| regWrData | output | 32 | Register write data |
| regRdEn | output | 1 | Register read strobe (data expected one cycle later) |
| regRdAddr | output | ADDR_W | Register read address, word aligned |
| regRdData | input | 32 | Register read data, valid in the cycle after regRdEn |
| fifoValid | output | 4 | One-hot beat strobe, one bit per FIFO port |
| fifoAddr | output | ADDR_W | Beat address, 16-byte aligned |
| fifoData | output | 128 | Beat data |

## Verification
The bench builds the block with its defaults: a 16-bit address, the page field at bit 12, FIFO pages starting at 4, and the page-7 split on bit 4. With these values a random address that spans pages 0 to 7 and the low six bits reaches every sink, both sides of the page-7 split, every word lane, both doubleword halves and every byte and halfword position. Roughly one request in four keeps random low bits, and one size code in six is the unknown code 5. Together these exercise both error causes alongside accepted traffic.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int NUM_FIFO = 4;
  localparam int FIFO_IDX_W = $clog2(NUM_FIFO);

  typedef struct packed {
    logic                capture;
    logic                directWr;
    logic [NUM_FIFO-1:0] fifoSel;
    logic                rmwRead;
    logic                rmwWrite;
  } strobe_t;
endpackage

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
#(
  parameter int FIFO_PAGE_LO = 4,
  parameter int SPLIT_BIT    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic [3:0]    reqPage,
  input  logic [SPLIT_BIT:0] reqLow,
  input  logic [2:0]    reqSize,
  output strobe_t       strb,
  output logic          busy,
  output logic          errFlag
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;
  state_e state;

  logic accept, sizeOk, alignOk, good, isSub, inFifo, dropBeat;
  logic [3:0] pageRel;
  logic [FIFO_IDX_W-1:0] fifoIdx;

  assign accept  = reqValid && (state == ST_IDLE);
  assign pageRel = reqPage - 4'(FIFO_PAGE_LO);
  assign inFifo  = (reqPage >= 4'(FIFO_PAGE_LO)) && (pageRel < 4'(NUM_FIFO));
  assign fifoIdx = pageRel[FIFO_IDX_W-1:0];
  assign dropBeat = (fifoIdx == FIFO_IDX_W'(NUM_FIFO - 1)) && !reqLow[SPLIT_BIT];
  assign isSub   = (reqSize <= 3'd1);

  always_comb begin
    sizeOk  = 1'b1;
    alignOk = 1'b1;
    case (reqSize)
      3'd0: alignOk = 1'b1;
      3'd1: alignOk = (reqLow[0] == 1'b0);
      3'd2: alignOk = (reqLow[1:0] == 2'b0);
      3'd3: alignOk = (reqLow[2:0] == 3'b0);
      3'd4: alignOk = (reqLow[3:0] == 4'b0);
      default: sizeOk = 1'b0;
    endcase
  end

  assign good = accept && sizeOk && alignOk;

  always_comb begin
    strb.capture  = good;
    strb.directWr = good && !isSub && !inFifo;
    strb.fifoSel  = (good && !isSub && inFifo && !dropBeat)
                    ? (NUM_FIFO'(1) << fifoIdx) : '0;
    strb.rmwRead  = (state == ST_READ);
    strb.rmwWrite = (state == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      errFlag <= accept && !(sizeOk && alignOk);
      case (state)
        ST_IDLE:  if (good && isSub) state <= ST_READ;
        ST_READ:  state <= ST_WRITE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bwa_datapath.sv
module bwa_datapath
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 128,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2:0]          reqSize,
  input  logic [BEAT_W-1:0]   reqData,
  input  logic [WORD_W-1:0]   regRdData,
  output logic                regWrEn,
  output logic [ADDR_W-1:0]   regWrAddr,
  output logic [WORD_W-1:0]   regWrData,
  output logic                regRdEn,
  output logic [ADDR_W-1:0]   regRdAddr,
  output logic [NUM_FIFO-1:0] fifoValid,
  output logic [ADDR_W-1:0]   fifoAddr,
  output logic [BEAT_W-1:0]   fifoData
);
  localparam int HALF_W  = WORD_W / 2;
  localparam int DWORD_W = WORD_W * 2;
  localparam int BEAT_BYTES_LOG = $clog2(BEAT_W / 8);

  logic [ADDR_W-1:0] holdAddr, wordAddr;
  logic              holdHalf;
  logic [HALF_W-1:0] holdData;
  logic              dirEnQ;
  logic [ADDR_W-1:0] dirAddrQ;
  logic [WORD_W-1:0] dirDataQ;
  logic [BEAT_W-1:0] beat;
  logic [WORD_W-1:0] merged;

  always_comb begin
    beat = '0;
    case (reqSize)
      3'd2:    beat[WORD_W*int'(reqAddr[3:2]) +: WORD_W] = reqData[WORD_W-1:0];
      3'd3:    beat[DWORD_W*int'(reqAddr[3]) +: DWORD_W] = reqData[DWORD_W-1:0];
      default: beat = reqData;
    endcase
  end

  always_comb begin
    merged = regRdData;
    if (holdHalf) merged[HALF_W*int'(holdAddr[1]) +: HALF_W] = holdData;
    else          merged[8*int'(holdAddr[1:0]) +: 8]         = holdData[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdAddr  <= '0;
      holdHalf  <= 1'b0;
      holdData  <= '0;
      dirEnQ    <= 1'b0;
      dirAddrQ  <= '0;
      dirDataQ  <= '0;
      fifoValid <= '0;
      fifoAddr  <= '0;
      fifoData  <= '0;
    end else begin
      dirEnQ    <= strb.directWr;
      fifoValid <= strb.fifoSel;
      if (strb.capture) begin
        holdAddr <= reqAddr;
        holdHalf <= reqSize[0];
        holdData <= reqData[HALF_W-1:0];
      end
      if (strb.directWr) begin
        dirAddrQ <= reqAddr;
        dirDataQ <= reqData[WORD_W-1:0];
      end
      if (|strb.fifoSel) begin
        fifoAddr <= {reqAddr[ADDR_W-1:BEAT_BYTES_LOG], BEAT_BYTES_LOG'(0)};
        fifoData <= beat;
      end
    end
  end

  assign wordAddr  = {holdAddr[ADDR_W-1:2], 2'b00};
  assign regRdEn   = strb.rmwRead;
  assign regRdAddr = wordAddr;
  assign regWrEn   = dirEnQ || strb.rmwWrite;
  assign regWrAddr = strb.rmwWrite ? wordAddr : dirAddrQ;
  assign regWrData = strb.rmwWrite ? merged : dirDataQ;
endmodule

// File: rtl/bus_write_adapter.sv
module bus_write_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_LSB     = 12,
  parameter int FIFO_PAGE_LO = 4,
  parameter int SPLIT_BIT    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2:0]          reqSize,
  input  logic [127:0]        reqData,
  output logic                busy,
  output logic                errFlag,
  output logic                regWrEn,
  output logic [ADDR_W-1:0]   regWrAddr,
  output logic [31:0]         regWrData,
  output logic                regRdEn,
  output logic [ADDR_W-1:0]   regRdAddr,
  input  logic [31:0]         regRdData,
  output logic [NUM_FIFO-1:0] fifoValid,
  output logic [ADDR_W-1:0]   fifoAddr,
  output logic [127:0]        fifoData
);
  strobe_t strb;

  bwa_ctrl #(.FIFO_PAGE_LO(FIFO_PAGE_LO), .SPLIT_BIT(SPLIT_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .reqPage(reqAddr[PAGE_LSB +: 4]), .reqLow(reqAddr[SPLIT_BIT:0]),
    .reqSize(reqSize), .strb(strb), .busy(busy), .errFlag(errFlag)
  );

  bwa_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqData(reqData), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdAddr(regRdAddr), .fifoValid(fifoValid),
    .fifoAddr(fifoAddr), .fifoData(fifoData)
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              errFlag,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regRdAddr,
  input logic [3:0]        fifoValid,
  input logic [ADDR_W-1:0] fifoAddr
);
  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regWrEn, regRdEn, fifoValid})); // R7

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> (!regWrEn && fifoValid == 4'b0)); // R12

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    regRdEn |=> (regWrEn && busy)); // R9

  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    regRdEn |=> (regWrAddr == $past(regRdAddr))); // R10

  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoValid != 4'b0) |-> ((fifoAddr & ADDR_W'(15)) == '0)); // R4

  AST_BUSY_IN_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    regRdEn |-> busy); // R11
endmodule

bind bus_write_adapter bwa_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .errFlag(errFlag),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regRdEn(regRdEn),
  .regRdAddr(regRdAddr), .fifoValid(fifoValid), .fifoAddr(fifoAddr)
);

// File: tb/sim_bus_write_adapter.sv
module sim_bus_write_adapter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reqValid = 1'b0;
  logic [15:0]  reqAddr = '0;
  logic [2:0]   reqSize = '0;
  logic [127:0] reqData = '0;
  logic         busy, errFlag, regWrEn, regRdEn;
  logic [15:0]  regWrAddr, regRdAddr, fifoAddr;
  logic [31:0]  regWrData;
  logic [31:0]  regRdData = '0;
  logic [3:0]   fifoValid;
  logic [127:0] fifoData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] memModel [0:127];

  always #4 clk = ~clk;

  bus_write_adapter u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqData(reqData), .busy(busy), .errFlag(errFlag),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .fifoValid(fifoValid), .fifoAddr(fifoAddr), .fifoData(fifoData)
  );

  function automatic int memIdx(logic [15:0] a);
    return int'({a[14:12], a[5:2]});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) memModel[i] <= 32'hA5C3_0000 ^ (i * 32'h0101_0107);
    end else begin
      if (regWrEn) memModel[memIdx(regWrAddr)] <= regWrData;
      if (regRdEn) regRdData <= memModel[memIdx(regRdAddr)];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit misaligned(logic [2:0] sz, logic [15:0] a);
    case (sz)
      3'd0: return 1'b0;
      3'd1: return a[0];
      3'd2: return a[1:0] != 0;
      3'd3: return a[2:0] != 0;
      3'd4: return a[3:0] != 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] mergeExp(logic [31:0] old, logic [2:0] sz, logic [15:0] a, logic [127:0] d);
    logic [31:0] r = old;
    if (sz == 3'd0) r[8*int'(a[1:0]) +: 8] = d[7:0];
    else r[16*int'(a[1]) +: 16] = d[15:0];
    return r;
  endfunction

  function automatic logic [127:0] beatExp(logic [2:0] sz, logic [15:0] a, logic [127:0] d);
    logic [127:0] b = '0;
    if (sz == 3'd2) b[32*int'(a[3:2]) +: 32] = d[31:0];
    else if (sz == 3'd3) b[64*int'(a[3]) +: 64] = d[63:0];
    else b = d;
    return b;
  endfunction

  task automatic doOp(input logic [2:0] sz, input logic [15:0] a, input logic [127:0] d);
    logic [31:0] old;
    logic [3:0] pg;
    logic [15:0] wa;
    pg = a[15:12];
    wa = {a[15:2], 2'b00};
    @(negedge clk);
    old = memModel[memIdx(a)];
    reqValid = 1'b1; reqSize = sz; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (misaligned(sz, a)) begin
      chk(errFlag === 1'b1, "R12 error pulse", 128'(errFlag), 128'(1));
      chk(!regWrEn && fifoValid == 0, "R12 no write", 128'({regWrEn, fifoValid}), 128'(0));
    end else if (sz <= 3'd1) begin
      chk(regRdEn && busy && regRdAddr == wa, sz == 0 ? "R9 read phase" : "R10 read phase",
          128'({regRdEn, busy, regRdAddr}), 128'({2'b11, wa}));
      @(negedge clk);
      chk(regWrEn && busy && regWrAddr == wa && regWrData == mergeExp(old, sz, a, d),
          sz == 0 ? "R9 merge write" : "R10 merge write",
          128'({regWrEn, busy, regWrAddr, regWrData}),
          128'({2'b11, wa, mergeExp(old, sz, a, d)}));
    end else if (pg >= 4 && pg <= 7) begin
      if (pg == 7 && !a[4]) begin
        chk(fifoValid == 0 && !regWrEn && !regRdEn && !errFlag, "R8 dropped",
            128'({fifoValid, regWrEn, regRdEn, errFlag}), 128'(0));
      end else begin
        chk(fifoValid == (4'b1 << (pg - 4)) && !regWrEn, "R7 sink select",
            128'({regWrEn, fifoValid}), 128'(4'b1 << (pg - 4)));
        chk(fifoAddr == {a[15:4], 4'b0}, "R4 beat address", 128'(fifoAddr), 128'({a[15:4], 4'b0}));
        chk(fifoData == beatExp(sz, a, d),
            sz == 2 ? "R4 word lane" : (sz == 3 ? "R5 doubleword half" : "R6 full beat"),
            fifoData, beatExp(sz, a, d));
      end
    end else begin
      chk(regWrEn && regWrAddr == a && regWrData == d[31:0] && fifoValid == 0,
          sz == 2 ? "R2 word write" : "R3 narrowed write",
          128'({regWrEn, regWrAddr, regWrData}), 128'({1'b1, a, d[31:0]}));
      @(negedge clk);
      chk(!regWrEn, "R2 single write", 128'(regWrEn), 128'(0));
    end
  endtask

  initial begin
    logic [31:0] oldX;
    int seedInit;
    seedInit = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !errFlag && !regWrEn && !regRdEn && fifoValid == 0, "R1 reset state",
        128'({busy, errFlag, regWrEn, regRdEn, fifoValid}), 128'(0));

    doOp(3'd2, 16'h1024, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    doOp(3'd4, 16'h2010, 128'hDEAD_BEEF_0000_0001_CAFE_F00D_1234_5678);
    doOp(3'd2, 16'h400C, 128'h0000_0000_0000_0000_0000_0000_ABCD_0123);
    doOp(3'd3, 16'h5008, 128'h0000_0000_0000_0000_0123_4567_89AB_CDEF);
    doOp(3'd4, 16'h6000, 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100);
    doOp(3'd4, 16'h7000, 128'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F);
    doOp(3'd2, 16'h7014, 128'h0000_0000_0000_0000_0000_0000_5A5A_A5A5);
    doOp(3'd0, 16'h0003, 128'h99);
    doOp(3'd1, 16'h3002, 128'hBEEF);
    doOp(3'd1, 16'h3001, 128'h1);
    doOp(3'd4, 16'h0008, 128'h2);
    doOp(3'd7, 16'h0000, 128'h3);

    // R11: request offered during read-modify-write is ignored
    oldX = memModel[memIdx(16'h0020)];
    @(negedge clk);
    reqValid = 1'b1; reqSize = 3'd0; reqAddr = 16'h0005; reqData = 128'h77;
    @(negedge clk);
    reqSize = 3'd2; reqAddr = 16'h0020; reqData = 128'h1234_5678;
    chk(busy === 1'b1, "R11 busy in read", 128'(busy), 128'(1));
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy && regWrAddr == 16'h0004, "R11 busy in write", 128'({busy, regWrAddr}), 128'({1'b1, 16'h0004}));
    @(negedge clk);
    chk(!regWrEn && !busy && memModel[memIdx(16'h0020)] == oldX, "R11 ignored request",
        128'({regWrEn, busy, memModel[memIdx(16'h0020)]}), 128'(oldX));

    for (int n = 0; n < 400; n++) begin
      logic [2:0] sz;
      logic [15:0] a;
      sz = 3'($urandom % 6);
      a  = {1'b0, 3'($urandom % 8), 6'b0, 6'($urandom)};
      if ($urandom % 4 != 0) begin
        case (sz)
          3'd1: a[0] = 1'b0;
          3'd2: a[1:0] = 2'b0;
          3'd3: a[2:0] = 3'b0;
          3'd4: a[3:0] = 4'b0;
          default: ;
        endcase
      end
      doOp(sz, a, {$urandom, $urandom, $urandom, $urandom});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule